// File: doc/BRIEF.md
# LCD Line Rate-Adapting FIFO

This block sits between the path that fetches display bytes from memory and a slow LCD driver. Bytes come in with a fast base shift strobe and are queued in an 80-byte buffer. They are then sent to the panel on a slower shift clock. That clock is the system clock divided by 2, 4 or 8, as set by a 2-bit rate field. The panel shift clock runs only while bytes are waiting. Each output byte changes together with a rising edge of that clock, so the panel can latch it on the falling edge.

A rising edge of the line pulse empties the buffer and restarts the output divider, so every display line starts from a known alignment. Rate code 00 is a pass-through mode. In that mode the base strobe and input byte go straight to the panel pins and the buffer is left untouched. Two sticky flags record a write dropped because the buffer was full, and a line pulse that arrived while bytes were still waiting. One input clears both flags.

All logic runs on one system clock. The incoming strobe and the line pulse are sampled and edge-detected in that clock.

Top module: `lcd_rate_fifo`

## Requirements
- R1: After reset with a divided rate selected, pnl_clk is 0, pnl_data is 0x00, and ovf_flag and late_flag are both 0.
- R2: With rate_sel = 00, pnl_clk equals base_stb and pnl_data equals base_data combinationally. Strobe edges seen in this mode write nothing: after switching to a divided rate with no new writes, pnl_clk produces no pulse.
- R3: A byte is captured at the system clock edge that first samples base_stb low after it was high. Captured bytes reach pnl_data in arrival order, one byte per shift clock pulse.
- R4: Rate codes 01, 10 and 11 give a shift clock period of 2, 4 and 8 system clock cycles. Each pulse is high for half of that period.
- R5: When the buffer is empty, pnl_clk stays low and pnl_data holds the last byte sent.
- R6: pnl_data takes a new byte at the same clock edge where pnl_clk rises.
- R7: A rising edge of line_pls empties the buffer and restarts the divider. If the line edge is sampled at clock edge L and a byte is captured at edge L+1, pnl_clk first rises at edge L+D+1, where D is the divide ratio.
- R8: A line pulse rising edge that finds the buffer non-empty sets the sticky late_flag. One that finds the buffer empty leaves late_flag unchanged.
- R9: The buffer holds 80 bytes. A capture while it is full is dropped and sets the sticky ovf_flag. The first 80 bytes of a long burst are delivered intact.
- R10: A cycle with clr_flags high clears ovf_flag and late_flag, unless the same cycle sets them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 2 | 00 pass-through; 01, 10 and 11 divide by 2, 4 and 8 |
| base_stb | input | 1 | Fast input shift strobe; a byte is captured on its falling edge |
| base_data | input | 8 | Input byte |
| line_pls | input | 1 | Line pulse; its rising edge flushes the buffer |
| clr_flags | input | 1 | Clears both sticky flags |
| pnl_clk | output | 1 | Panel shift clock |
| pnl_data | output | 8 | Panel data byte |
| ovf_flag | output | 1 | Sticky flag: a write was dropped on a full buffer |
| late_flag | output | 1 | Sticky flag: a line pulse arrived with bytes still waiting |

## Verification
For each divided rate the bench measures the delay from the line edge to the first pulse, the pulse spacing and the high width, and compares each with arithmetic on the ratio. A divider that did not restart, or that popped at the wrong count, would shift all of these times. A burst longer than the buffer checks that exactly the first 80 bytes come out in order and that later bytes are dropped. An off-by-one full test would lose or corrupt a byte at the boundary. Flushing while bytes are waiting must set late_flag and stop the shift clock. Strobe edges in pass-through mode must leave nothing behind. A design that wrote in that mode would emit stray pulses once a divided rate was selected.

// File: rtl/lcd_rate_fifo_pkg.sv
package lcd_rate_fifo_pkg;

  typedef enum logic [1:0] {
    RATE_PASS = 2'b00,
    RATE_DIV2 = 2'b01,
    RATE_DIV4 = 2'b10,
    RATE_DIV8 = 2'b11
  } rate_e;

  // Divide ratio for a rate code; pass-through reports 1.
  function automatic int unsigned rate_div(input logic [1:0] code);
    return (code == RATE_PASS) ? 1 : (32'd1 << code);
  endfunction

  // Modulo-depth pointer step, for a buffer depth that need not be a power of two.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/lrf_edge.sv
module lrf_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic hit
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= RISING ? 1'b1 : 1'b0;
    else        sig_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = sig & ~sig_q;
    end else begin : g_fall
      assign hit = ~sig & sig_q;
    end
  endgenerate
endmodule

// File: rtl/lrf_buf.sv
module lrf_buf #(
  parameter int DEPTH = 80,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int OCW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           wr_req,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_req,
  output logic [DW-1:0]  rd_data,
  output logic [OCW-1:0] occ,
  output logic           empty,
  output logic           wr_drop
);
  import lcd_rate_fifo_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, do_wr, do_rd;

  assign full    = (occ == OCW'(DEPTH));
  assign empty   = (occ == '0);
  assign do_wr   = wr_req & ~full & ~flush;
  assign do_rd   = rd_req & ~empty & ~flush;
  assign wr_drop = wr_req & full & ~flush;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_wr) wp <= PW'(wrap_inc(int'(wp), DEPTH));
      if (do_rd) rp <= PW'(wrap_inc(int'(rp), DEPTH));
      case ({do_wr, do_rd})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/lrf_shift.sv
module lrf_shift #(
  parameter int MAX_DIV = 8,
  localparam int CW     = $clog2(MAX_DIV),
  localparam int DVW    = CW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           restart,
  input  logic [DVW-1:0] div,
  input  logic           avail,
  output logic           pop,
  output logic           sclk
);
  logic [CW-1:0] cnt;

  assign pop = ~hold & ~restart & avail & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (hold || restart) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      if ({1'b0, cnt} >= div - 1'b1) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
      if (pop)                                 sclk <= 1'b1;
      else if ({1'b0, cnt} == (div >> 1))      sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_rate_fifo.sv
module lcd_rate_fifo #(
  parameter int DEPTH   = 80,
  parameter int DW      = 8,
  parameter int MAX_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rate_sel,
  input  logic          base_stb,
  input  logic [DW-1:0] base_data,
  input  logic          line_pls,
  input  logic          clr_flags,
  output logic          pnl_clk,
  output logic [DW-1:0] pnl_data,
  output logic          ovf_flag,
  output logic          late_flag
);
  import lcd_rate_fifo_pkg::*;

  localparam int OCW = $clog2(DEPTH + 1);
  localparam int DVW = $clog2(MAX_DIV) + 1;

  // Named internal events, observed by the bound checker.
  logic           bypass, stb_fall, line_rise, wr_req, rd_evt, empty, wr_drop, late_evt, sclk;
  logic [OCW-1:0] occ;
  logic [DW-1:0]  head, data_q;
  logic [DVW-1:0] div_val;

  assign bypass   = (rate_sel == RATE_PASS);
  assign div_val  = DVW'(rate_div(rate_sel));
  assign wr_req   = stb_fall & ~bypass;
  assign late_evt = line_rise & ~empty;

  lrf_edge #(.RISING(1'b0)) u_stb_edge (
    .clk(clk), .rst_n(rst_n), .sig(base_stb), .hit(stb_fall)
  );

  lrf_edge #(.RISING(1'b1)) u_line_edge (
    .clk(clk), .rst_n(rst_n), .sig(line_pls), .hit(line_rise)
  );

  lrf_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(line_rise),
    .wr_req(wr_req), .wr_data(base_data),
    .rd_req(rd_evt), .rd_data(head),
    .occ(occ), .empty(empty), .wr_drop(wr_drop)
  );

  lrf_shift #(.MAX_DIV(MAX_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold(bypass), .restart(line_rise),
    .div(div_val), .avail(~empty), .pop(rd_evt), .sclk(sclk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      ovf_flag  <= 1'b0;
      late_flag <= 1'b0;
    end else begin
      if (rd_evt) data_q <= head;
      ovf_flag  <= (ovf_flag  & ~clr_flags) | wr_drop;
      late_flag <= (late_flag & ~clr_flags) | late_evt;
    end
  end

  assign pnl_clk  = bypass ? base_stb  : sclk;
  assign pnl_data = bypass ? base_data : data_q;
endmodule

// File: rtl/lcd_rate_fifo_chk.sv
module lcd_rate_fifo_chk #(
  parameter int DEPTH = 80,
  parameter int OCW   = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bypass,
  input logic           wr_req,
  input logic           wr_drop,
  input logic           rd_evt,
  input logic           line_rise,
  input logic [OCW-1:0] occ,
  input logic           pnl_clk,
  input logic           clr_flags,
  input logic           ovf_flag,
  input logic           late_flag
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCW'(DEPTH)); // R9
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> occ != '0); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |=> occ == '0); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && occ == OCW'(DEPTH) && !line_rise) |=> ovf_flag); // R9
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf_flag); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flags) |=> ovf_flag); // R9
  AST_LATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise && occ != '0) |=> late_flag); // R8
  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (late_flag && !clr_flags) |=> late_flag); // R8
  AST_RISE_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $past(!bypass) && $rose(pnl_clk)) |-> $past(rd_evt)); // R6
  AST_PASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !line_rise) |=> $stable(occ)); // R2
endmodule

bind lcd_rate_fifo lcd_rate_fifo_chk #(.DEPTH(DEPTH), .OCW(OCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .wr_req(wr_req), .wr_drop(wr_drop),
  .rd_evt(rd_evt), .line_rise(line_rise), .occ(occ), .pnl_clk(pnl_clk),
  .clr_flags(clr_flags), .ovf_flag(ovf_flag), .late_flag(late_flag)
);

// File: tb/lcd_rate_fifo_bench.sv
`timescale 1ns/1ps
module lcd_rate_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b01;
  logic       base_stb = 1'b0;
  logic [7:0] base_data = 8'h00;
  logic       line_pls = 1'b0;
  logic       clr_flags = 1'b0;
  logic       pnl_clk;
  logic [7:0] pnl_data;
  logic       ovf_flag, late_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  bit       mon_en = 1'b0;
  logic     prev_clk = 1'b0;
  int       n_rise = 0;
  int       rise_cyc [0:255];
  int       fall_cyc [0:255];
  logic [7:0] rise_dat [0:255];

  always #10 clk = ~clk;

  lcd_rate_fifo u_lcd_rate_fifo (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .base_stb(base_stb),
    .base_data(base_data), .line_pls(line_pls), .clr_flags(clr_flags),
    .pnl_clk(pnl_clk), .pnl_data(pnl_data), .ovf_flag(ovf_flag), .late_flag(late_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_en && n_rise < 256) begin
      if (pnl_clk && !prev_clk) begin
        rise_cyc[n_rise] = cyc;
        rise_dat[n_rise] = pnl_data;
        n_rise = n_rise + 1;
      end else if (!pnl_clk && prev_clk && n_rise > 0) begin
        fall_cyc[n_rise-1] = cyc;
      end
    end
    prev_clk = pnl_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    base_data = b; base_stb = 1'b1; tick();
    base_stb = 1'b0; tick();
  endtask

  task automatic line_edge();
    line_pls = 1'b1; tick();
    line_pls = 1'b0; tick();
  endtask

  task automatic clear_flags();
    clr_flags = 1'b1; tick();
    clr_flags = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, dv, l_cyc, snap;
    bit ok;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(pnl_clk == 1'b0, "R1 clk", pnl_clk, 0);
    chk(pnl_data == 8'h00, "R1 data", pnl_data, 0);
    chk(!ovf_flag && !late_flag, "R1 flags", {ovf_flag, late_flag}, 0);

    // Divided rates: R3 R4 R5 R6 R7
    mon_en = 1'b1;
    for (int r = 1; r < 4; r++) begin
      dv = 1 << r;
      rate_sel = 2'(r);
      clear_flags();
      base = n_rise;
      // line edge sampled at edge L, first byte captured at L+1
      line_pls = 1'b1; base_stb = 1'b1; base_data = 8'(r * 16 + 1); tick();
      l_cyc = cyc;
      line_pls = 1'b0; base_stb = 1'b0; tick();
      for (int i = 1; i < 10; i++) put_byte(8'(r * 16 + 1 + i));
      tick(12 * dv + 20);
      chk(n_rise - base == 10, "R3 count", n_rise - base, 10);
      ok = 1'b1;
      for (int i = 0; i < 10; i++) if (rise_dat[base + i] != 8'(r * 16 + 1 + i)) ok = 1'b0;
      chk(ok, "R3 R6 order", rise_dat[base + 9], r * 16 + 10);
      chk(rise_cyc[base] - l_cyc == dv + 1, "R7 first pulse", rise_cyc[base] - l_cyc, dv + 1);
      ok = 1'b1;
      for (int i = 0; i < 9; i++) if (rise_cyc[base + i + 1] - rise_cyc[base + i] != dv) ok = 1'b0;
      chk(ok, "R4 period", rise_cyc[base + 1] - rise_cyc[base], dv);
      chk(fall_cyc[base] - rise_cyc[base] == dv / 2, "R4 high width",
          fall_cyc[base] - rise_cyc[base], dv / 2);
      chk(pnl_clk == 1'b0, "R5 idle clk", pnl_clk, 0);
      chk(pnl_data == 8'(r * 16 + 10), "R5 hold data", pnl_data, r * 16 + 10);
      chk(!late_flag && !ovf_flag, "R8 empty line edge", late_flag, 0);
    end

    // R8 late line edge, R7 flush, R10 clear
    rate_sel = 2'b11;
    for (int i = 0; i < 6; i++) put_byte(8'h50 + 8'(i));
    line_edge();
    chk(late_flag == 1'b1, "R8 late set", late_flag, 1);
    snap = n_rise;
    tick(40);
    chk(n_rise == snap, "R7 flush stops output", n_rise - snap, 0);
    chk(pnl_clk == 1'b0, "R7 clk low", pnl_clk, 0);
    clear_flags();
    chk(late_flag == 1'b0, "R10 late cleared", late_flag, 0);

    // R9 overflow with depth 80
    base = n_rise;
    line_edge();
    for (int i = 0; i < 130; i++) put_byte(8'(i));
    chk(ovf_flag == 1'b1, "R9 ovf set", ovf_flag, 1);
    tick(900);
    ok = 1'b1;
    for (int i = 0; i < 80; i++) if (rise_dat[base + i] != 8'(i)) ok = 1'b0;
    chk(ok, "R9 first 80 intact", rise_dat[base + 79], 79);
    chk(n_rise - base < 130 && n_rise - base >= 80, "R9 drops", n_rise - base, 100);
    clear_flags();
    chk(ovf_flag == 1'b0, "R10 ovf cleared", ovf_flag, 0);

    // R2 pass-through
    mon_en = 1'b0;
    rate_sel = 2'b00;
    tick();
    for (int i = 0; i < 8; i++) begin
      base_stb = i[0]; base_data = 8'hA0 + 8'(i);
      #2;
      chk(pnl_clk == base_stb && pnl_data == base_data, "R2 follow", pnl_data, 8'hA0 + i);
      tick();
    end
    base_stb = 1'b0;
    tick();
    rate_sel = 2'b01;
    tick();
    prev_clk = pnl_clk;
    mon_en = 1'b1;
    snap = n_rise;
    tick(30);
    chk(n_rise == snap, "R2 no write", n_rise - snap, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule